// File: doc/BRIEF.md
# Five-Port Router Switch Scheduler

This block is the control-side arbiter of a five-port mesh router: four neighbour directions plus one local port. Each input buffer raises a request, gives the 2-bit priority class of its head flit, and names the output port that route computation chose for it. For every output port that is free, the scheduler picks one winner among the inputs aiming at that port. It returns the winner's priority class on that input's 2-bit grant bus, asks the target output buffer whether it has room, and waits for the reply. Once room is reported, it pulses a one-cycle confirm to the winning input, which then hands the flit to the datapath and pops its head.

A 2-bit mode input selects the arbitration policy. The policies are oldest-waiting-first, plain round-robin, strict priority, and round-robin within the highest pending priority class. Each output port runs its own handshake, so inputs aimed at different outputs progress in parallel. The flit storage and the crossbar are outside this block.

Top module: `rsw_sched`

## Requirements
- R1: After reset every grant slot reads 00, and every space query and every confirm is low.
- R2: A request counts only when its priority code is nonzero and its destination field is below 5. When such a request targets an idle output, the winner's grant slot shows its priority code (01 high, 10 mid, 11 low) one clock edge after the request is presented.
- R3: While a grant is held, the space query of the target output stays high until the available reply is seen at a clock edge. The confirm bit of the winning input is then high for exactly one cycle, and the grant slot returns to 00 on the following edge.
- R4: An output serves at most one input at a time. Inputs aimed at different outputs are granted in the same cycle.
- R5: Mode 0 (oldest first) grants the requester that has waited the most cycles since its last confirm, regardless of priority. Among equal wait ages the lowest input index wins.
- R6: Mode 1 (round-robin) grants the first requester after the last confirmed winner of that output, in cyclic index order, regardless of priority. After reset the search starts at input 0.
- R7: Mode 2 (strict priority) grants the best priority class. Among inputs of that class the lowest input index wins, including one that was just served.
- R8: Mode 3 (priority round-robin) restricts the choice to the best pending class and rotates within that class from the last confirmed winner. A lower class is served only when no better class is pending.
- R9: The grant code and the winner of an output stay fixed from grant to confirm, even when the input's priority changes meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Policy: 0 oldest first, 1 round-robin, 2 strict priority, 3 priority round-robin |
| req_i | input | 5 | Per-input request: a head flit is waiting |
| pri_i | input | 10 | Per-input head priority, bits [2i+1:2i]: 00 none, 01 high, 10 mid, 11 low |
| dst_i | input | 15 | Per-input target output, bits [3i+2:3i], valid 0..4 |
| space_avail_i | input | 5 | Per-output reply: output buffer has room |
| grant_o | output | 10 | Per-input grant, bits [2i+1:2i], carrying the granted priority code or 00 |
| space_req_o | output | 5 | Per-output space query |
| confirm_o | output | 5 | Per-input one-cycle transfer confirm |

## Verification
Several inputs contend for one output while that output is held busy, so that each policy's choice shows up as the next grant after a confirm. Unequal wait ages with inverted priorities separate oldest-first from strict priority. A set of re-requesting equal-class inputs separates round-robin rotation from fixed lowest-index choice. Mixed classes under priority round-robin show that rotation stays inside the high class and that the mid class waits for it. Separate patterns cover parallel grants to distinct outputs, requests with a zero priority or an out-of-range destination that must be ignored, and a priority change during a held grant.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  typedef enum logic [1:0] {
    POL_OLDEST = 2'd0,
    POL_RR     = 2'd1,
    POL_PRIO   = 2'd2,
    POL_PRR    = 2'd3
  } pol_e;

  typedef enum logic [1:0] {
    OST_IDLE = 2'd0,
    OST_WAIT = 2'd1,
    OST_CONF = 2'd2
  } ost_e;

  localparam logic [1:0] PRI_NONE = 2'b00;
endpackage

// File: rtl/rsw_age.sv
module rsw_age #(
  parameter int N     = 5,
  parameter int AGE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       req_i,
  input  logic [N-1:0]       busy_i,
  input  logic [N-1:0]       conf_i,
  output logic [N*AGE_W-1:0] age_o
);
  localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

  for (genvar i = 0; i < N; i++) begin : g_cnt
    logic [AGE_W-1:0] age_q, age_d;
    logic             age_en;

    always_comb begin
      age_en = conf_i[i] || (req_i[i] && !busy_i[i] && (age_q != AGE_MAX));
      age_d  = conf_i[i] ? '0 : age_q + AGE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      age_q <= '0;
      else if (age_en) age_q <= age_d;
    end

    assign age_o[i*AGE_W +: AGE_W] = age_q;
  end
endmodule

// File: rtl/rsw_outport.sv
module rsw_outport
  import rsw_pkg::*;
#(
  parameter int N      = 5,
  parameter int OUT_ID = 0,
  parameter int AGE_W  = 4,
  parameter int DW     = 3,
  parameter int IW     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pol_e               pol_i,
  input  logic [N-1:0]       req_i,
  input  logic [2*N-1:0]     pri_i,
  input  logic [N*DW-1:0]    dst_i,
  input  logic [N*AGE_W-1:0] age_i,
  input  logic               space_avail_i,
  output logic               space_req_o,
  output logic               busy_o,
  output logic               conf_o,
  output logic [IW-1:0]      win_o,
  output logic [1:0]         code_o
);
  localparam int KW = (AGE_W > 2) ? AGE_W : 2;

  ost_e          st_q, st_d;
  logic [IW-1:0] win_q, ptr_q, pick, start;
  logic [1:0]    code_q;
  logic [N-1:0]  cand;
  logic [KW-1:0] key [N];
  logic [KW-1:0] best;
  logic          found, win_en, ptr_en;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cand[i] = req_i[i] && (pri_i[2*i +: 2] != PRI_NONE) &&
                (dst_i[i*DW +: DW] == DW'(OUT_ID));
      unique case (pol_i)
        POL_OLDEST:       key[i] = KW'(age_i[i*AGE_W +: AGE_W]);
        POL_PRIO, POL_PRR: key[i] = KW'(2'd3 - pri_i[2*i +: 2]);
        default:          key[i] = '0;
      endcase
    end
    if ((pol_i == POL_RR) || (pol_i == POL_PRR))
      start = (ptr_q == IW'(N-1)) ? '0 : ptr_q + IW'(1);
    else
      start = '0;
  end

  always_comb begin
    int idx;
    found = 1'b0;
    best  = '0;
    pick  = '0;
    for (int k = 0; k < N; k++) begin
      idx = int'(start) + k;
      if (idx >= N) idx = idx - N;
      if (cand[idx] && (!found || key[idx] > best)) begin
        found = 1'b1;
        best  = key[idx];
        pick  = IW'(idx);
      end
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      OST_IDLE: if (found)         st_d = OST_WAIT;
      OST_WAIT: if (space_avail_i) st_d = OST_CONF;
      default:                     st_d = OST_IDLE;
    endcase
    win_en = (st_q == OST_IDLE) && found;
    ptr_en = (st_q == OST_CONF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= OST_IDLE;
      win_q  <= '0;
      code_q <= PRI_NONE;
      ptr_q  <= IW'(N-1);
    end else begin
      st_q <= st_d;
      if (win_en) begin
        win_q  <= pick;
        code_q <= pri_i[2*pick +: 2];
      end
      if (ptr_en) ptr_q <= win_q;
    end
  end

  assign busy_o      = (st_q != OST_IDLE);
  assign conf_o      = (st_q == OST_CONF);
  assign space_req_o = (st_q == OST_WAIT);
  assign win_o       = win_q;
  assign code_o      = code_q;

  // R3: a pending space query is held until it is answered
  p_hold_query_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (space_req_o && !space_avail_i) |=> space_req_o);
  // R3: confirm only after an answered query
  p_conf_after_avail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conf_o |-> $past(space_req_o && space_avail_i));
  // R3: confirm lasts one cycle
  p_conf_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    conf_o |=> !conf_o);
  // R9: winner and code frozen while the handshake runs
  p_win_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !conf_o) |=> ($stable(win_o) && $stable(code_o)));
endmodule

// File: rtl/rsw_sched.sv
module rsw_sched
  import rsw_pkg::*;
#(
  parameter int N     = 5,
  parameter int AGE_W = 4,
  parameter int DW    = $clog2(N),
  parameter int IW    = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_i,
  input  logic [N-1:0]    req_i,
  input  logic [2*N-1:0]  pri_i,
  input  logic [N*DW-1:0] dst_i,
  input  logic [N-1:0]    space_avail_i,
  output logic [2*N-1:0]  grant_o,
  output logic [N-1:0]    space_req_o,
  output logic [N-1:0]    confirm_o
);
  pol_e               pol;
  logic [N*AGE_W-1:0] age;
  logic [N-1:0]       out_busy, out_conf, in_busy;
  logic [IW-1:0]      out_win  [N];
  logic [1:0]         out_code [N];
  logic [N-1:0]       hold     [N];

  assign pol = pol_e'(mode_i);

  rsw_age #(.N(N), .AGE_W(AGE_W)) u_age (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .busy_i (in_busy),
    .conf_i (confirm_o),
    .age_o  (age)
  );

  for (genvar o = 0; o < N; o++) begin : g_out
    rsw_outport #(.N(N), .OUT_ID(o), .AGE_W(AGE_W), .DW(DW), .IW(IW)) u_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .pol_i         (pol),
      .req_i         (req_i),
      .pri_i         (pri_i),
      .dst_i         (dst_i),
      .age_i         (age),
      .space_avail_i (space_avail_i[o]),
      .space_req_o   (space_req_o[o]),
      .busy_o        (out_busy[o]),
      .conf_o        (out_conf[o]),
      .win_o         (out_win[o]),
      .code_o        (out_code[o])
    );
  end

  always_comb begin
    grant_o   = '0;
    confirm_o = '0;
    in_busy   = '0;
    for (int i = 0; i < N; i++) begin
      hold[i] = '0;
      for (int o = 0; o < N; o++) begin
        if (out_busy[o] && (out_win[o] == IW'(i))) begin
          hold[i][o]       = 1'b1;
          in_busy[i]       = 1'b1;
          grant_o[2*i +: 2] = grant_o[2*i +: 2] | out_code[o];
          if (out_conf[o]) confirm_o[i] = 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R4: an input is held by at most one output
    p_one_holder_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hold[i]));
    // R3: a confirm always goes to an input that holds a grant
    p_conf_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      confirm_o[i] |-> (grant_o[2*i +: 2] != PRI_NONE));
    // R3: grant released the edge after the confirm
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      confirm_o[i] |=> (grant_o[2*i +: 2] == PRI_NONE));
  end
endmodule

// File: tb/rsw_sched_tb.sv
`timescale 1ns/1ps
module rsw_sched_tb_top;
  localparam int N = 5;
  localparam logic [1:0] HI = 2'b01, MID = 2'b10, LO = 2'b11;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     mode;
  logic [N-1:0]   req;
  logic [2*N-1:0] pri;
  logic [3*N-1:0] dst;
  logic [N-1:0]   avail;
  logic [2*N-1:0] grant;
  logic [N-1:0]   sreq, conf;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rsw_sched dut_i (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .req_i(req), .pri_i(pri),
    .dst_i(dst), .space_avail_i(avail), .grant_o(grant),
    .space_req_o(sreq), .confirm_o(conf)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gs(input int i);
    return int'(grant[2*i +: 2]);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_in(input int i, input bit r, input logic [1:0] p, input int d);
    req[i]         = r;
    pri[2*i +: 2]  = p;
    dst[3*i +: 3]  = 3'(d);
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; mode = m; req = '0; pri = '0; dst = '0; avail = '0;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  // answer output o, check confirm to input i, optionally re-request
  task automatic serve(input int o, input int i, input bit keep, input string tag);
    avail[o] = 1'b1;
    step();
    chk({tag, " confirm"}, int'(conf[i]), 1);
    if (!keep) req[i] = 1'b0;
    avail[o] = 1'b0;
    step();
    step();
  endtask

  task automatic t_reset();
    do_reset(2'd2);
    chk("R1 grant idle", int'(grant), 0);
    chk("R1 query idle", int'(sreq), 0);
    chk("R1 confirm idle", int'(conf), 0);
  endtask

  task automatic t_basic();
    do_reset(2'd2);
    set_in(0, 1, 2'b00, 1);
    set_in(1, 1, HI, 6);
    step(); step();
    chk("R2 ignored grant", int'(grant), 0);
    chk("R2 ignored query", int'(sreq), 0);
    set_in(0, 0, 2'b00, 0); set_in(1, 0, 2'b00, 0);
    set_in(2, 1, MID, 3);
    step();
    chk("R2 grant code", gs(2), 2);
    chk("R3 query up", int'(sreq), 8);
    chk("R3 no early confirm", int'(conf), 0);
    pri[5:4] = HI;
    step(); step(); step();
    chk("R9 code held", gs(2), 2);
    chk("R3 query held", int'(sreq[3]), 1);
    avail[3] = 1'b1;
    step();
    chk("R3 confirm", int'(conf), 4);
    req[2] = 1'b0; avail[3] = 1'b0;
    step();
    chk("R3 confirm pulse", int'(conf), 0);
    chk("R3 grant released", gs(2), 0);
  endtask

  task automatic t_parallel();
    do_reset(2'd2);
    set_in(0, 1, MID, 1);
    set_in(1, 1, MID, 2);
    set_in(2, 1, MID, 1);
    step();
    chk("R4 in0 granted", gs(0), 2);
    chk("R4 in1 granted", gs(1), 2);
    chk("R4 in2 waits", gs(2), 0);
    chk("R4 two queries", int'(sreq), 6);
  endtask

  task automatic t_oldest();
    do_reset(2'd0);
    set_in(4, 1, LO, 0);
    step();
    chk("R5 first", gs(4), 3);
    set_in(3, 1, LO, 0);
    step(); step(); step();
    set_in(1, 1, HI, 0);
    set_in(2, 1, HI, 0);
    step();
    serve(0, 4, 0, "R5 a");
    chk("R5 oldest wins", gs(3), 3);
    chk("R5 high waits", gs(1), 0);
    serve(0, 3, 0, "R5 b");
    chk("R5 tie lowest", gs(1), 1);
    chk("R5 tie other", gs(2), 0);
  endtask

  task automatic t_rr();
    do_reset(2'd1);
    set_in(0, 1, LO, 2);
    set_in(2, 1, LO, 2);
    set_in(4, 1, HI, 2);
    step();
    chk("R6 start 0", gs(0), 3);
    serve(2, 0, 1, "R6 a");
    chk("R6 next 2", gs(2), 3);
    serve(2, 2, 1, "R6 b");
    chk("R6 next 4", gs(4), 1);
    serve(2, 4, 1, "R6 c");
    chk("R6 wrap 0", gs(0), 3);
  endtask

  task automatic t_prio();
    do_reset(2'd2);
    set_in(0, 1, LO, 3);
    step();
    chk("R7 first", gs(0), 3);
    set_in(1, 1, LO, 3);
    set_in(2, 1, MID, 3);
    set_in(4, 1, MID, 3);
    serve(3, 0, 1, "R7 a");
    chk("R7 mid first", gs(2), 2);
    serve(3, 2, 0, "R7 b");
    chk("R7 mid next", gs(4), 2);
    serve(3, 4, 0, "R7 c");
    chk("R7 low idx0 again", gs(0), 3);
    serve(3, 0, 0, "R7 d");
    chk("R7 last", gs(1), 3);
  endtask

  task automatic t_prr();
    do_reset(2'd3);
    set_in(0, 1, HI, 4);
    set_in(1, 1, MID, 4);
    set_in(3, 1, HI, 4);
    step();
    chk("R8 first", gs(0), 1);
    serve(4, 0, 1, "R8 a");
    chk("R8 rotate 3", gs(3), 1);
    chk("R8 mid waits", gs(1), 0);
    serve(4, 3, 1, "R8 b");
    chk("R8 rotate 0", gs(0), 1);
    serve(4, 0, 0, "R8 c");
    chk("R8 high 3", gs(3), 1);
    serve(4, 3, 0, "R8 d");
    chk("R8 mid served", gs(1), 2);
  endtask

  initial begin
    rst_n = 1'b0; mode = '0; req = '0; pri = '0; dst = '0; avail = '0;
    t_reset();
    t_basic();
    t_parallel();
    t_oldest();
    t_rr();
    t_prio();
    t_prr();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule